// File: doc/BRIEF.md
# Ring Oscillator Pair Frequency Comparator

This block decides which of two free-running oscillator signals is faster. A challenge names two of the `NUM_OSC` oscillator inputs as the first and second member of a pair. A start strobe opens a counting window whose length, in system clock cycles, comes with the strobe. While the window is open, one counter per pair member counts rising edges of its oscillator. When the window closes, the block compares the two counts and returns one response bit with a one-cycle done strobe. Stepping the challenge between windows produces a bit string.

Each oscillator input is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector before it reaches a counter. The oscillators must therefore run below half the system clock rate. A longer window and wider counters separate pairs whose frequencies are close. The counters saturate rather than wrap. Equal counts set a separate tie flag.

The controller is a three-state machine:
- **IDLE** waits for start. On the transition IDLE→RUN (start seen), it captures the challenge and window length and clears both counters.
- **RUN** counts. It takes the transition RUN→RUN while more than one window cycle remains, and RUN→DECIDE on the last window cycle.
- **DECIDE** compares the counts. It always returns to IDLE (DECIDE→IDLE), registering the response, the tie flag and done.

Top module: `ro_pair_cmp`

## Requirements
- R1: After reset, `resp`, `tie` and `done` are 0 and the block waits in IDLE.
- R2: `sel_a`, `sel_b` and `win_len` are sampled only on the clock edge that accepts `start` in IDLE. Later changes have no effect on the window under way.
- R3: A window accepted at clock edge E0 counts during the next W edges, where W = max(`win_len`, 1). `done` is high for exactly the cycle after edge E0+W+1.
- R4: A rising edge of a selected oscillator is counted once, two clock edges after the edge that first samples it high, provided that counting edge falls inside the window.
- R5: At the end of a window, `resp` is 0 when the first member's count exceeds the second's, and 1 when it is lower.
- R6: When the two counts are equal, `resp` is 1 and `tie` is 1. Otherwise `tie` is 0.
- R7: Each counter holds at 2^CNT_W-1 instead of wrapping, so two oscillators that both reach that value tie.
- R8: `done` lasts one cycle. `resp` and `tie` keep their value until the next accepted start, which clears both to 0 on its accepting edge.
- R9: A `start` pulse that arrives while a window is counting or deciding is ignored and does not move the end of the window.
- R10: Selecting the same oscillator for both pair members always yields a tie.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that times the window |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | NUM_OSC | Asynchronous oscillator signals |
| start | input | 1 | Opens a window when the block is idle |
| sel_a | input | SEL_W | Index of the first pair member |
| sel_b | input | SEL_W | Index of the second pair member |
| win_len | input | WIN_W | Window length in clock cycles (0 counts as 1) |
| resp | output | 1 | 0 if the first member is faster, else 1 |
| tie | output | 1 | Counts were equal in the last window |
| done | output | 1 | One-cycle strobe when a response is ready |

## Verification
The bench runs windows long enough that both counters saturate, where a wrapping counter would report the fast oscillator as faster instead of returning a tie. It also covers:
- a zero-length window, where an off-by-one in the window timer moves `done` by a cycle;
- challenge changes in mid-window, which a design that reads the live select would turn into the opposite response;
- a second start pulse during a window, which a design that re-arms would answer late;
- same-index and in-phase pairs, where a strict comparison for the tie case would return 0.

Each cycle, a queue-based model that tracks the two-edge synchronizer latency is compared with `resp`, `tie` and `done`, so a missing or extra synchronizer stage shows up as a count mismatch.

// File: rtl/ro_pair_cmp_pkg.sv
package ro_pair_cmp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_DECIDE = 2'd2
    } cmp_state_e;
endpackage

// File: rtl/ro_edge_sync.sv
// Two-flop synchronizer followed by a rising-edge detector.
module ro_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_pulse = sync_q & ~prev_q;
endmodule

// File: rtl/ro_sat_counter.sv
// Edge counter that clears on request and holds at its maximum.
module ro_sat_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/ro_pair_cmp.sv
module ro_pair_cmp
    import ro_pair_cmp_pkg::*;
#(
    parameter int NUM_OSC = 8,
    parameter int CNT_W   = 12,
    parameter int WIN_W   = 16,
    localparam int SEL_W  = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OSC-1:0] osc_in,
    input  logic               start,
    input  logic [SEL_W-1:0]   sel_a,
    input  logic [SEL_W-1:0]   sel_b,
    input  logic [WIN_W-1:0]   win_len,
    output logic               resp,
    output logic               tie,
    output logic               done
);
    localparam int PAD_N = 1 << SEL_W;

    cmp_state_e         state_q, state_d;
    logic [SEL_W-1:0]   sel_a_q, sel_b_q;
    logic [WIN_W-1:0]   rem_q;
    logic [NUM_OSC-1:0] edge_vec;
    logic [PAD_N-1:0]   edge_pad;
    logic [CNT_W-1:0]   cnt_a, cnt_b;
    logic               accept, last_cycle, cnt_clr, cnt_en;
    logic               resp_q, tie_q, done_q;

    // One synchronizer per oscillator so a challenge change never creates a false edge.
    for (genvar g = 0; g < NUM_OSC; g++) begin : g_sync
        ro_edge_sync u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .async_in   (osc_in[g]),
            .rise_pulse (edge_vec[g])
        );
    end

    assign edge_pad   = PAD_N'(edge_vec);
    assign accept     = (state_q == ST_IDLE) && start;
    assign last_cycle = (rem_q <= WIN_W'(1));
    assign cnt_clr    = accept;
    assign cnt_en     = (state_q == ST_RUN);

    ro_sat_counter #(.W(CNT_W)) u_cnt_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_en & edge_pad[sel_a_q]),
        .count (cnt_a)
    );

    ro_sat_counter #(.W(CNT_W)) u_cnt_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_en & edge_pad[sel_b_q]),
        .count (cnt_b)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RUN;
            ST_RUN:    if (last_cycle) state_d = ST_DECIDE;
            ST_DECIDE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Challenge latch and window timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_a_q <= '0;
            sel_b_q <= '0;
            rem_q   <= '0;
        end else if (accept) begin
            sel_a_q <= sel_a;
            sel_b_q <= sel_b;
            rem_q   <= win_len;
        end else if ((state_q == ST_RUN) && !last_cycle) begin
            rem_q   <= rem_q - WIN_W'(1);
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= 1'b0;
            tie_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_DECIDE);
            if (state_q == ST_DECIDE) begin
                resp_q <= ~(cnt_a > cnt_b);
                tie_q  <= (cnt_a == cnt_b);
            end else if (accept) begin
                resp_q <= 1'b0;
                tie_q  <= 1'b0;
            end
        end
    end

    assign resp = resp_q;
    assign tie  = tie_q;
    assign done = done_q;
endmodule

// File: rtl/ro_pair_cmp_chk.sv
module ro_pair_cmp_chk
    import ro_pair_cmp_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             resp,
    input logic             tie,
    input logic             done,
    input cmp_state_e       state_q,
    input logic [SEL_W-1:0] sel_a_q,
    input logic [CNT_W-1:0] cnt_a,
    input logic             cnt_clr
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    tie_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tie |-> resp);

    // R8
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(resp) && !done) |-> $past(start));

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_a == {CNT_W{1'b1}}) && !cnt_clr) |=> (cnt_a == {CNT_W{1'b1}}));

    // R2
    sel_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(sel_a_q));

    // R3
    done_after_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE) |=> done);
endmodule

bind ro_pair_cmp ro_pair_cmp_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .resp    (resp),
    .tie     (tie),
    .done    (done),
    .state_q (state_q),
    .sel_a_q (sel_a_q),
    .cnt_a   (cnt_a),
    .cnt_clr (cnt_clr)
);

// File: tb/ro_pair_cmp_tb_top.sv
`timescale 1ns/1ps
module ro_pair_cmp_tb_top;
    localparam int N   = 4;
    localparam int CW  = 8;
    localparam int WW  = 12;
    localparam int SW  = 2;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  osc = '0;
    logic          start = 1'b0;
    logic [SW-1:0] sel_a = '0, sel_b = '0;
    logic [WW-1:0] win_len = '0;
    logic          resp, tie, done;

    int checks = 0;
    int errors = 0;
    bit fin = 0;

    always #2 clk = ~clk;

    ro_pair_cmp #(.NUM_OSC(N), .CNT_W(CW), .WIN_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_in(osc), .start(start),
        .sel_a(sel_a), .sel_b(sel_b), .win_len(win_len),
        .resp(resp), .tie(tie), .done(done)
    );

    // Oscillator stimulus: channel i toggles every hp[i] cycles.
    int hp [N] = '{1, 3, 2, 2};
    int ph [N] = '{0, 0, 0, 0};
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            ph[i] = ph[i] + 1;
            if (ph[i] >= hp[i]) begin
                ph[i] = 0;
                osc[i] = ~osc[i];
            end
        end
    end

    // Behavioural reference model
    logic [N-1:0] hist [$];
    int  m_st = 0, m_rem = 0, m_ca = 0, m_cb = 0, m_a = 0, m_b = 0;
    bit  m_resp = 0, m_tie = 0, m_done = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i < 3; i++) hist.push_back('0);
            m_st = 0; m_resp = 0; m_tie = 0; m_done = 0; m_ca = 0; m_cb = 0;
        end else begin
            logic [N-1:0] pulse;
            pulse = hist[1] & ~hist[2];
            m_done = 0;
            case (m_st)
                0: if (start) begin
                    m_a = int'(sel_a); m_b = int'(sel_b); m_rem = int'(win_len);
                    m_ca = 0; m_cb = 0; m_resp = 0; m_tie = 0; m_st = 1;
                end
                1: begin
                    if (pulse[m_a] && m_ca < MAXC) m_ca++;
                    if (pulse[m_b] && m_cb < MAXC) m_cb++;
                    if (m_rem <= 1) m_st = 2;
                    else m_rem--;
                end
                default: begin
                    m_resp = (m_ca > m_cb) ? 1'b0 : 1'b1;
                    m_tie  = (m_ca == m_cb);
                    m_done = 1;
                    m_st   = 0;
                end
            endcase
            hist.push_front(osc);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R4 R5 resp vs model", int'(resp), int'(m_resp));
            chk("R6 tie vs model", int'(tie), int'(m_tie));
            chk("R3 done vs model", int'(done), int'(m_done));
        end
    end

    // Runs one window; returns negedges from the start drive until done is seen.
    task automatic run_win(input int a, input int b, input int len,
                           input bit swap_mid, input bit restart_mid, output int cyc);
        int n;
        @(negedge clk);
        sel_a = SW'(a); sel_b = SW'(b); win_len = WW'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        // R8: accepted start clears the previous result
        chk("R8 resp cleared on start", int'(resp), 0);
        chk("R8 tie cleared on start", int'(tie), 0);
        if (swap_mid) begin
            sel_a = SW'(b); sel_b = SW'(a); win_len = WW'(3);
        end
        if (restart_mid) start = 1'b1;
        while (!done && n < 5000) begin
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        cyc = n;
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 resp after reset", int'(resp), 0);
        chk("R1 tie after reset", int'(tie), 0);
        chk("R1 done after reset", int'(done), 0);

        // R5: fast first member
        run_win(0, 1, 40, 0, 0, c);
        chk("R3 window timing len 40", c, 42);
        chk("R5 fast first gives 0", int'(resp), 0);
        chk("R6 no tie", int'(tie), 0);

        // R5: slow first member
        run_win(1, 0, 40, 0, 0, c);
        chk("R5 slow first gives 1", int'(resp), 1);

        // R10: same oscillator twice
        run_win(2, 2, 30, 0, 0, c);
        chk("R10 same index tie", int'(tie), 1);
        chk("R10 same index resp", int'(resp), 1);

        // R3: zero length counts as one cycle
        run_win(0, 1, 0, 0, 0, c);
        chk("R3 zero window timing", c, 3);

        // R2: challenge changed mid-window
        run_win(0, 1, 40, 1, 0, c);
        chk("R2 latched select resp", int'(resp), 0);
        chk("R2 latched length timing", c, 42);

        // R9: extra start while busy
        run_win(0, 1, 20, 0, 1, c);
        chk("R9 busy start ignored timing", c, 22);
        repeat (4) @(negedge clk);
        chk("R9 no second done", int'(done), 0);

        // R7: both counters saturate
        run_win(0, 2, 1200, 0, 0, c);
        chk("R7 saturated tie", int'(tie), 1);
        chk("R7 saturated resp", int'(resp), 1);

        // R6: equal-frequency in-phase pair
        run_win(2, 3, 30, 0, 0, c);
        chk("R6 equal tie", int'(tie), 1);
        chk("R6 equal resp", int'(resp), 1);

        // R8: result holds, done is a single cycle
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R8 resp holds", int'(resp), 1);
            chk("R8 done single cycle", int'(done), 0);
        end

        // R8: next start clears the tie result (checked inside run_win)
        run_win(0, 1, 10, 0, 0, c);
        chk("R5 short window resp", int'(resp), 0);

        repeat (3) @(negedge clk);
        fin = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!fin) begin
            fin = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule